// File: doc/BRIEF.md
# Descriptor-Driven Configuration Item DMA Engine

This engine moves bytes out of a store of numbered configuration items into system memory under the control of a descriptor. Software places a 16-byte descriptor in memory and pulses the start input with the descriptor's address. The engine reads the descriptor one byte at a time. It can optionally switch to a different item, then either copies bytes of the current item to the destination address or skips over them. Finally it writes a big-endian status word back over the first four bytes of the descriptor.

The current item and the read offset inside it are kept between transfers, so a long item can be drained by several descriptors in a row. Reads past the end of an item, or from an item the store reports as absent, produce zero bytes. A skip advances the item offset without touching memory. The memory side is a byte-wide request/response port with a valid/ready request handshake and an error flag on every response. The item side is a combinational lookup by item number and byte offset.

Top module: `cfgdma_engine`

## Requirements
- R1: After reset, busy_o is low, no memory request is raised, and the current item is 0 at offset 0.
- R2: On an accepted start, the engine issues exactly 16 byte reads at descriptor address +0 to +15 in increasing order. Bytes 0-3 form the control word, 4-7 the length and 8-15 the destination address, all most significant byte first.
- R3: If control bit 3 (select) is 1, the current item becomes control bits 31:16 and its offset becomes 0 before any data byte is written.
- R4: Control bit 1 (read) takes priority over bit 2 (skip). With neither bit set, no data byte is written, and the status is 0.
- R5: A read writes one byte per position at destination, destination+1, and so on. While the item is present and its offset is below its length, each byte is the item byte at the current offset, and the offset then advances by one. The offset persists into the next transfer.
- R6: When the item is absent, has length 0, or its offset has reached its length, a read writes 0x00 for every remaining position and the offset does not move.
- R7: A skip writes no data bytes. It advances the item offset by the smaller of the length and the bytes left in the item.
- R8: At the end, the engine writes 4 status bytes at descriptor address +0 to +3, most significant first. The status is 0 on success and 1 when a data write got an error response. The first failing write ends the data phase, and only successfully written bytes advance the offset.
- R9: An error response while reading the descriptor stops the fetch at once. The engine writes status 1 and leaves the current item and offset unchanged.
- R10: busy_o rises the cycle after an accepted start and falls after the response to the last status write. Start pulses while busy_o is high are ignored.
- R11: A memory request holds its address, direction and write data stable until accepted. The engine waits for that request's response before issuing the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| desc_addr_i | input | 64 | Descriptor address sampled with start |
| busy_o | output | 1 | Transfer in progress |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_write_o | output | 1 | 1 for write, 0 for read |
| mem_req_addr_o | output | ADDR_W | Byte address |
| mem_req_wdata_o | output | 8 | Write byte |
| mem_rsp_valid_i | input | 1 | Response for the accepted request |
| mem_rsp_rdata_i | input | 8 | Read byte |
| mem_rsp_err_i | input | 1 | Access failed |
| item_sel_o | output | SEL_W | Current item number |
| item_off_o | output | 32 | Current offset inside the item |
| item_valid_i | input | 1 | Selected item exists |
| item_len_i | input | 32 | Length of the selected item |
| item_data_i | input | 8 | Item byte at the current offset |

## Verification
Directed descriptors walk one item across several transfers. They show whether the offset is carried over, and whether the change from item bytes to zero fill falls exactly at the item's end. Other descriptors target an absent item, an empty item, both flags, neither flag, and zero length. These separate the read-over-skip priority from the no-op path and from zero fill. Injected error responses on a data write, and on a descriptor byte, show whether the data phase stops early and whether the selection in an aborted descriptor leaks. A second start pulse during a transfer shows whether starts are gated by busy. Random descriptors with random memory stalls and latencies are then checked against a byte-level reference model of item, offset and destination contents.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
   localparam int LEN_W      = 32;
   localparam int DESC_BYTES = 16;
   localparam int STAT_BYTES = 4;
   localparam int FLAG_READ  = 1;
   localparam int FLAG_SKIP  = 2;
   localparam int FLAG_SEL   = 3;
   localparam int SEL_LSB    = 16;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FETCH_REQ,
      ST_FETCH_RSP,
      ST_DECODE,
      ST_RUN,
      ST_WR_REQ,
      ST_WR_RSP,
      ST_STAT_REQ,
      ST_STAT_RSP
   } eng_state_t;
endpackage

// File: rtl/cfgdma_desc_shift.sv
module cfgdma_desc_shift #(
   parameter int NBYTES = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr_i,
   input  logic        shift_i,
   input  logic [7:0]  byte_i,
   output logic [15:0] sel_o,
   output logic        flag_read_o,
   output logic        flag_skip_o,
   output logic        flag_sel_o,
   output logic [31:0] len_o,
   output logic [63:0] addr_o
);
   import cfgdma_pkg::*;
   localparam int VEC_W = NBYTES * 8;

   generate
      if (NBYTES != 16) begin : g_bad_size
         $error("cfgdma_desc_shift: descriptor must be 16 bytes");
      end
   endgenerate

   logic [VEC_W-1:0] vec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vec_q <= '0;
      else if (clr_i)   vec_q <= '0;
      else if (shift_i) vec_q <= {vec_q[VEC_W-9:0], byte_i};
   end

   // first byte fetched ends up most significant: big-endian fields
   logic [31:0] ctl_w;
   assign ctl_w       = vec_q[127:96];
   assign len_o       = vec_q[95:64];
   assign addr_o      = vec_q[63:0];
   assign sel_o       = ctl_w[31:SEL_LSB];
   assign flag_read_o = ctl_w[FLAG_READ];
   assign flag_skip_o = ctl_w[FLAG_SKIP];
   assign flag_sel_o  = ctl_w[FLAG_SEL];

   logic unused_ctl_bits;
   assign unused_ctl_bits = ^{ctl_w[15:4], ctl_w[0]};
endmodule

// File: rtl/cfgdma_chunk_calc.sv
module cfgdma_chunk_calc #(
   parameter int W = 32
) (
   input  logic [W-1:0] remain_i,
   input  logic         item_ok_i,
   input  logic [W-1:0] item_len_i,
   input  logic [W-1:0] item_off_i,
   output logic         usable_o,
   output logic [W-1:0] chunk_o
);
   logic [W-1:0] left_w;

   assign usable_o = item_ok_i && (item_off_i < item_len_i);
   assign left_w   = item_len_i - item_off_i;

   always_comb begin
      if (!usable_o)              chunk_o = remain_i;
      else if (remain_i < left_w) chunk_o = remain_i;
      else                        chunk_o = left_w;
   end
endmodule

// File: rtl/cfgdma_status_lane.sv
module cfgdma_status_lane #(
   parameter int NBYTES = 4,
   localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
   input  logic [NBYTES*8-1:0] word_i,
   input  logic [IDX_W-1:0]    idx_i,
   output logic [7:0]          byte_o
);
   logic [7:0] lanes [NBYTES];

   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_lane
         // lane 0 carries the most significant byte
         assign lanes[b] = word_i[(NBYTES-1-b)*8 +: 8];
      end
   endgenerate

   assign byte_o = lanes[idx_i];
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine #(
   parameter int ADDR_W = 64,
   parameter int SEL_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [63:0]       desc_addr_i,
   output logic              busy_o,
   output logic              mem_req_valid_o,
   input  logic              mem_req_ready_i,
   output logic              mem_req_write_o,
   output logic [ADDR_W-1:0] mem_req_addr_o,
   output logic [7:0]        mem_req_wdata_o,
   input  logic              mem_rsp_valid_i,
   input  logic [7:0]        mem_rsp_rdata_i,
   input  logic              mem_rsp_err_i,
   output logic [SEL_W-1:0]  item_sel_o,
   output logic [31:0]       item_off_o,
   input  logic              item_valid_i,
   input  logic [31:0]       item_len_i,
   input  logic [7:0]        item_data_i
);
   import cfgdma_pkg::*;

   localparam int IDX_W  = $clog2(DESC_BYTES);
   localparam int SIDX_W = $clog2(STAT_BYTES);

   generate
      if (ADDR_W < 12 || ADDR_W > 64) begin : g_bad_addr
         $error("cfgdma_engine: ADDR_W out of range");
      end
      if (SEL_W < 1 || SEL_W > 16) begin : g_bad_sel
         $error("cfgdma_engine: SEL_W out of range");
      end
   endgenerate

   eng_state_t        state_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] dst_q;
   logic [IDX_W-1:0]  idx_q;
   logic [SEL_W-1:0]  cur_sel_q;
   logic [LEN_W-1:0]  cur_off_q;
   logic [LEN_W-1:0]  remain_q;
   logic              is_read_q;
   logic              err_q;

   logic [15:0]       d_sel;
   logic              d_read, d_skip, d_select;
   logic [31:0]       d_len;
   logic [63:0]       d_addr;
   logic              usable;
   logic [LEN_W-1:0]  chunk;
   logic [7:0]        stat_byte;

   logic fetch_clr, fetch_shift;
   assign fetch_clr   = (state_q == ST_IDLE) && start_i;
   assign fetch_shift = (state_q == ST_FETCH_RSP) && mem_rsp_valid_i && !mem_rsp_err_i;

   cfgdma_desc_shift #(.NBYTES(DESC_BYTES)) u_desc (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (fetch_clr),
      .shift_i     (fetch_shift),
      .byte_i      (mem_rsp_rdata_i),
      .sel_o       (d_sel),
      .flag_read_o (d_read),
      .flag_skip_o (d_skip),
      .flag_sel_o  (d_select),
      .len_o       (d_len),
      .addr_o      (d_addr)
   );

   cfgdma_chunk_calc #(.W(LEN_W)) u_chunk (
      .remain_i   (remain_q),
      .item_ok_i  (item_valid_i),
      .item_len_i (item_len_i),
      .item_off_i (cur_off_q),
      .usable_o   (usable),
      .chunk_o    (chunk)
   );

   cfgdma_status_lane #(.NBYTES(STAT_BYTES)) u_stat (
      .word_i (32'(err_q)),
      .idx_i  (idx_q[SIDX_W-1:0]),
      .byte_o (stat_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         base_q    <= '0;
         dst_q     <= '0;
         idx_q     <= '0;
         cur_sel_q <= '0;
         cur_off_q <= '0;
         remain_q  <= '0;
         is_read_q <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               base_q  <= desc_addr_i[ADDR_W-1:0];
               idx_q   <= '0;
               err_q   <= 1'b0;
               state_q <= ST_FETCH_REQ;
            end
            ST_FETCH_REQ: if (mem_req_ready_i) state_q <= ST_FETCH_RSP;
            ST_FETCH_RSP: if (mem_rsp_valid_i) begin
               if (mem_rsp_err_i) begin
                  err_q   <= 1'b1;
                  idx_q   <= '0;
                  state_q <= ST_STAT_REQ;
               end else if (idx_q == IDX_W'(DESC_BYTES - 1)) begin
                  state_q <= ST_DECODE;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_FETCH_REQ;
               end
            end
            ST_DECODE: begin
               if (d_select) begin
                  cur_sel_q <= d_sel[SEL_W-1:0];
                  cur_off_q <= '0;
               end
               is_read_q <= d_read;
               remain_q  <= (d_read || d_skip) ? d_len : '0;
               dst_q     <= d_addr[ADDR_W-1:0];
               state_q   <= ST_RUN;
            end
            ST_RUN: begin
               if (remain_q == '0) begin
                  idx_q   <= '0;
                  state_q <= ST_STAT_REQ;
               end else if (is_read_q) begin
                  state_q <= ST_WR_REQ;
               end else begin
                  remain_q <= remain_q - chunk;
                  dst_q    <= dst_q + ADDR_W'(chunk);
                  if (usable) cur_off_q <= cur_off_q + chunk;
               end
            end
            ST_WR_REQ: if (mem_req_ready_i) state_q <= ST_WR_RSP;
            ST_WR_RSP: if (mem_rsp_valid_i) begin
               if (mem_rsp_err_i) begin
                  err_q   <= 1'b1;
                  idx_q   <= '0;
                  state_q <= ST_STAT_REQ;
               end else begin
                  remain_q <= remain_q - 1'b1;
                  dst_q    <= dst_q + 1'b1;
                  if (usable) cur_off_q <= cur_off_q + 1'b1;
                  state_q  <= ST_RUN;
               end
            end
            ST_STAT_REQ: if (mem_req_ready_i) state_q <= ST_STAT_RSP;
            ST_STAT_RSP: if (mem_rsp_valid_i) begin
               if (idx_q[SIDX_W-1:0] == SIDX_W'(STAT_BYTES - 1)) begin
                  state_q <= ST_IDLE;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_STAT_REQ;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_valid_o = 1'b0;
      mem_req_write_o = 1'b0;
      mem_req_addr_o  = '0;
      mem_req_wdata_o = '0;
      unique case (state_q)
         ST_FETCH_REQ: begin
            mem_req_valid_o = 1'b1;
            mem_req_addr_o  = base_q + ADDR_W'(idx_q);
         end
         ST_WR_REQ: begin
            mem_req_valid_o = 1'b1;
            mem_req_write_o = 1'b1;
            mem_req_addr_o  = dst_q;
            mem_req_wdata_o = usable ? item_data_i : 8'h00;
         end
         ST_STAT_REQ: begin
            mem_req_valid_o = 1'b1;
            mem_req_write_o = 1'b1;
            mem_req_addr_o  = base_q + ADDR_W'(idx_q[SIDX_W-1:0]);
            mem_req_wdata_o = stat_byte;
         end
         default: ;
      endcase
   end

   assign busy_o     = (state_q != ST_IDLE);
   assign item_sel_o = cur_sel_q;
   assign item_off_o = cur_off_q;
endmodule

// File: rtl/cfgdma_engine_chk.sv
module cfgdma_engine_chk #(
   parameter int ADDR_W = 64,
   parameter int SEL_W  = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   start_i,
   input logic                   busy_o,
   input logic                   mem_req_valid_o,
   input logic                   mem_req_ready_i,
   input logic                   mem_req_write_o,
   input logic [ADDR_W-1:0]      mem_req_addr_o,
   input logic [7:0]             mem_req_wdata_o,
   input logic                   mem_rsp_valid_i,
   input logic [SEL_W-1:0]       item_sel_o,
   input logic [31:0]            item_off_o,
   input logic                   item_valid_i,
   input logic [31:0]            item_len_i,
   input cfgdma_pkg::eng_state_t state_q
);
   import cfgdma_pkg::*;

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_valid_o);

   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid_o && !mem_req_ready_i |=>
         mem_req_valid_o && $stable(mem_req_addr_o) &&
         $stable(mem_req_write_o) && $stable(mem_req_wdata_o));

   assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(mem_rsp_valid_i));

   assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WR_REQ) && !(item_valid_i && (item_off_o < item_len_i))
         |-> (mem_req_wdata_o == 8'h00));

   assert_item_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> $stable(item_sel_o) && $stable(item_off_o));
endmodule

bind cfgdma_engine cfgdma_engine_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .start_i         (start_i),
   .busy_o          (busy_o),
   .mem_req_valid_o (mem_req_valid_o),
   .mem_req_ready_i (mem_req_ready_i),
   .mem_req_write_o (mem_req_write_o),
   .mem_req_addr_o  (mem_req_addr_o),
   .mem_req_wdata_o (mem_req_wdata_o),
   .mem_rsp_valid_i (mem_rsp_valid_i),
   .item_sel_o      (item_sel_o),
   .item_off_o      (item_off_o),
   .item_valid_i    (item_valid_i),
   .item_len_i      (item_len_i),
   .state_q         (state_q)
);

// File: tb/sim_cfgdma_engine.sv
module sim_cfgdma_engine;
   localparam int ADDR_W = 64;
   localparam int SEL_W  = 16;
   localparam int NITEMS = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [63:0]       desc_addr_i = '0;
   logic              busy_o;
   logic              mem_req_valid_o;
   logic              mem_req_ready_i = 1'b0;
   logic              mem_req_write_o;
   logic [ADDR_W-1:0] mem_req_addr_o;
   logic [7:0]        mem_req_wdata_o;
   logic              mem_rsp_valid_i = 1'b0;
   logic [7:0]        mem_rsp_rdata_i = '0;
   logic              mem_rsp_err_i = 1'b0;
   logic [SEL_W-1:0]  item_sel_o;
   logic [31:0]       item_off_o;
   logic              item_valid_i;
   logic [31:0]       item_len_i;
   logic [7:0]        item_data_i;

   always #2.5 clk = ~clk;

   cfgdma_engine #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u0 (.*);

   // ---------------- item store model ----------------
   int len_tab [NITEMS];

   function automatic logic [7:0] ibyte(int s, int o);
      return 8'(s * 37 + o * 11 + 5);
   endfunction

   always_comb begin
      item_valid_i = (int'(item_sel_o) < NITEMS);
      item_len_i   = item_valid_i ? 32'(len_tab[int'(item_sel_o) % NITEMS]) : 32'd0;
      item_data_i  = ibyte(int'(item_sel_o), int'(item_off_o));
   end

   // ---------------- memory model ----------------
   logic [7:0] mem [4096];
   int  err_addr = -1;
   int  rd_cnt, wr_cnt, cur_dbase;
   bit  rd_bad;
   bit  acc_now = 0, have_pend = 0;
   int  pend_dly;
   logic [11:0] c_addr;
   logic        c_wr;
   logic [7:0]  c_data;

   task automatic deliver();
      bit e;
      e = (int'(c_addr) == err_addr);
      mem_rsp_valid_i = 1'b1;
      mem_rsp_err_i   = e;
      if (c_wr) begin
         if (!e) mem[c_addr] = c_data;
         wr_cnt++;
      end else begin
         mem_rsp_rdata_i = mem[c_addr];
         if (int'(c_addr) != cur_dbase + rd_cnt) rd_bad = 1;
         rd_cnt++;
      end
   endtask

   initial begin
      forever begin
         @(negedge clk);
         mem_rsp_valid_i = 1'b0;
         mem_rsp_err_i   = 1'b0;
         if (have_pend) begin
            if (pend_dly == 0) begin deliver(); have_pend = 0; end
            else pend_dly--;
         end
         if (acc_now) begin
            pend_dly = $urandom % 3;
            if (pend_dly == 0) deliver();
            else begin pend_dly--; have_pend = 1; end
         end
         mem_req_ready_i = (($urandom % 4) != 0);
         acc_now = rst_n && mem_req_valid_o && mem_req_ready_i;
         if (acc_now) begin
            c_addr = mem_req_addr_o[11:0];
            c_wr   = mem_req_write_o;
            c_data = mem_req_wdata_o;
         end
      end
   end

   // ---------------- checking ----------------
   int n_chk = 0, n_fail = 0;
   int r_sel = 0, r_off = 0;

   task automatic chk(bit ok, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog R10: actual busy expected idle");
      finish_run();
   end

   task automatic wait_idle();
      int c = 0;
      while (busy_o && c < 5000) begin @(negedge clk); c++; end
      chk(!busy_o, "R10 transfer hung", busy_o, 0);
   endtask

   task automatic put_desc(int d, logic [31:0] ctl, int len, int dst);
      logic [127:0] v;
      v = {ctl, 32'(len), 64'(dst)};
      for (int k = 0; k < 16; k++) mem[d + k] = v[127 - 8*k -: 8];
   endtask

   task automatic pulse_start(int d);
      start_i = 1'b1; desc_addr_i = 64'(d);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic do_xfer(int dbase, logic [31:0] ctl, int len, int dst,
                          int eoff, bit intrude, string tag);
      logic [7:0] exp_b [64];
      bit rd, exp_err, usable;
      int n, nw, bad_k;
      logic [31:0] st;
      put_desc(dbase, ctl, len, dst);
      for (int k = -1; k <= len; k++) mem[dst + k] = 8'hAA;
      if (ctl[3]) begin r_sel = int'(ctl[31:16]); r_off = 0; end
      rd = ctl[1];
      n  = (ctl[1] || ctl[2]) ? len : 0;
      exp_err = rd && eoff >= 0 && eoff < n;
      nw = exp_err ? eoff : n;
      for (int k = 0; k < 64; k++) exp_b[k] = 8'hAA;
      for (int k = 0; k < nw; k++) begin
         usable = (r_sel < NITEMS) && (r_off < len_tab[r_sel % NITEMS]);
         if (rd) exp_b[k] = usable ? ibyte(r_sel, r_off) : 8'h00;
         if (usable) r_off++;
      end
      err_addr  = (eoff >= 0) ? dst + eoff : -1;
      rd_cnt = 0; wr_cnt = 0; rd_bad = 0; cur_dbase = dbase;
      pulse_start(dbase);
      chk(busy_o == 1'b1, {tag, " R10 busy after start"}, busy_o, 1);
      if (intrude) begin
         put_desc(12'h1F0, 32'h0003_000A, 4, 12'h700);
         repeat (3) @(negedge clk);
         chk(busy_o == 1'b1, "R10 still busy", busy_o, 1);
         pulse_start(12'h1F0);
      end
      wait_idle();
      err_addr = -1;
      st = {mem[dbase], mem[dbase+1], mem[dbase+2], mem[dbase+3]};
      chk(st == 32'(exp_err), {tag, " R8 status"}, st, 32'(exp_err));
      bad_k = -1;
      for (int k = 0; k < len; k++) if (bad_k < 0 && mem[dst+k] !== exp_b[k]) bad_k = k;
      chk(bad_k < 0, {tag, " data R5"}, (bad_k < 0) ? 0 : mem[dst+bad_k],
          (bad_k < 0) ? 0 : exp_b[bad_k]);
      chk(mem[dst-1] == 8'hAA && mem[dst+len] == 8'hAA, {tag, " R5 guard"},
          {mem[dst-1], mem[dst+len]}, 16'hAAAA);
      chk(rd_cnt == 16 && !rd_bad, {tag, " R2 fetch"}, rd_cnt, 16);
      chk(wr_cnt == (rd ? (exp_err ? nw + 1 : n) : 0) + 4, {tag, " R7 write count"},
          wr_cnt, (rd ? (exp_err ? nw + 1 : n) : 0) + 4);
      if (intrude)
         chk({mem[12'h1F0], mem[12'h1F1], mem[12'h1F2], mem[12'h1F3]} == 32'h0003_000A,
             "R10 second start ignored", {mem[12'h1F0], mem[12'h1F1]}, 16'h0003);
   endtask

   task automatic do_fetch_err(int dbase, int ebyte);
      logic [31:0] st;
      put_desc(dbase, 32'h0002_000A, 4, 12'h600);
      mem[12'h5FF] = 8'hAA; mem[12'h600] = 8'hAA;
      err_addr = dbase + ebyte;
      rd_cnt = 0; wr_cnt = 0; rd_bad = 0; cur_dbase = dbase;
      pulse_start(dbase);
      wait_idle();
      err_addr = -1;
      st = {mem[dbase], mem[dbase+1], mem[dbase+2], mem[dbase+3]};
      chk(st == 32'd1, "R9 fetch error status", st, 1);
      chk(rd_cnt == ebyte + 1, "R9 fetch stops", rd_cnt, ebyte + 1);
      chk(wr_cnt == 4, "R9 only status written", wr_cnt, 4);
      chk(mem[12'h600] == 8'hAA, "R9 no data", mem[12'h600], 8'hAA);
   endtask

   initial begin
      void'($urandom(32'd1234));
      len_tab = '{5, 1, 12, 3, 8, 0, 16, 0};
      for (int k = 0; k < 4096; k++) mem[k] = 8'h00;
      repeat (4) @(negedge clk);
      chk(busy_o == 1'b0, "R1 busy at reset", busy_o, 0);
      chk(mem_req_valid_o == 1'b0, "R1 no request at reset", mem_req_valid_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(item_sel_o == 0 && item_off_o == 0, "R1 item at reset", item_off_o, 0);

      do_xfer(12'h100, 32'h0002_000A, 5,  12'h400, -1, 0, "R3 select+read");
      do_xfer(12'h110, 32'h0000_0002, 10, 12'h420, -1, 0, "R6 run past end");
      do_xfer(12'h120, 32'h0000_0002, 4,  12'h440, -1, 0, "R6 at end");
      do_xfer(12'h130, 32'h0000_000C, 3,  12'h460, -1, 0, "R7 skip");
      do_xfer(12'h140, 32'h0000_0002, 4,  12'h480, -1, 0, "R7 after skip");
      do_xfer(12'h150, 32'h0009_000A, 3,  12'h4A0, -1, 0, "R6 absent item");
      do_xfer(12'h160, 32'h0005_000A, 2,  12'h4C0, -1, 0, "R6 empty item");
      do_xfer(12'h170, 32'h0001_000E, 3,  12'h4E0, -1, 0, "R4 read over skip");
      do_xfer(12'h180, 32'h0006_0008, 10, 12'h500, -1, 0, "R4 no flags");
      do_xfer(12'h190, 32'h0000_0002, 2,  12'h520, -1, 0, "R3 offset reset");
      do_xfer(12'h1A0, 32'h0000_0002, 8,  12'h540, 3, 0,  "R8 write error");
      do_xfer(12'h1B0, 32'h0000_0002, 2,  12'h560, -1, 0, "R8 offset after error");
      do_xfer(12'h1C0, 32'h0000_0002, 0,  12'h580, -1, 0, "R5 zero length");
      do_fetch_err(12'h1D0, 5);
      do_xfer(12'h1E0, 32'h0000_0002, 3,  12'h5A0, -1, 0, "R9 item kept");
      do_xfer(12'h100, 32'h0004_000A, 6,  12'h5C0, -1, 1, "R10 start during busy");

      for (int i = 0; i < 40; i++) begin
         logic [31:0] ctl;
         ctl = {16'($urandom % 10), 12'h000, 1'b0, 3'($urandom % 8)} & 32'hFFFF_000E;
         ctl[3] = ($urandom % 2 == 0);
         do_xfer(12'h100 + (i % 8) * 16, ctl, $urandom % 20,
                 12'h400 + ($urandom % 64) * 16, -1, 0, "R5 random");
      end
      finish_run();
   end
endmodule